// File: doc/BRIEF.md
# Pseudo-Balanced Nibble Line Encoder and Decoder

This block sends 4-bit data words over five single-ended lines using a 5-bit code word whose weight is always two or three. On the transmit side it also drives a sixth output, a balancing bit that feeds a local dummy load and is never sent over the channel. That bit is set exactly when the code word has two ones. As a result, the six driver outputs hold three high levels in every cycle, so the current drawn from the supply does not depend on the data. Fully balanced signalling would need six lines to get the same constant current; this scheme uses five.

The receive side takes the five received bits back to the original nibble. It flags any word that is not one of the sixteen code words in use. The encoder and the decoder are independent clocked paths that share one clock and one reset. Each path has a valid input and a registered valid output. An asynchronous active-low reset is released synchronously inside the block.

Top module: `pbal_link`

## Requirements
- R1: The code for nibble n is the (n+1)-th smallest 5-bit value whose weight is two or three. The code book is 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 17, 18, 19, 20, 21, 22 for n = 0 to 15.
- R2: `enc_code_o` always has exactly two or three bits set.
- R3: `enc_bal_o` is 1 when `enc_code_o` has two ones and 0 when it has three. The sum of the ones in `enc_code_o` and `enc_bal_o` is three in every cycle, including during reset.
- R4: A word accepted with `enc_valid_i` high appears on `enc_code_o` and `enc_bal_o` on the next clock edge, with `enc_valid_o` high for that cycle.
- R5: While `enc_valid_i` is low, `enc_code_o` and `enc_bal_o` keep their last values and `enc_valid_o` is low on the next cycle.
- R6: A received code word from the R1 book with `dec_valid_i` high yields its nibble on `dec_data_o` one cycle later, with `dec_valid_o` high and `dec_err_o` low.
- R7: A received word of weight 0, 1, 4 or 5 with `dec_valid_i` high sets `dec_err_o` one cycle later.
- R8: A received word of weight two or three that is not in the R1 book (24, 25, 26, 28) sets `dec_err_o` one cycle later.
- R9: In a cycle where `dec_err_o` is high, `dec_valid_o` is low and `dec_data_o` holds its last decoded nibble.
- R10: After reset, `enc_code_o` = 3, `enc_bal_o` = 1, `dec_data_o` = 0, and all valid and error outputs are low.
- R11: While `dec_valid_i` is low, the next cycle has `dec_valid_o` and `dec_err_o` low and `dec_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid_i | input | 1 | Nibble on enc_data_i is to be encoded |
| enc_data_i | input | 4 | Nibble to transmit |
| enc_valid_o | output | 1 | A new code word was loaded this cycle |
| enc_code_o | output | 5 | Code word driven on the five lines |
| enc_bal_o | output | 1 | Balancing bit for the local dummy load |
| dec_valid_i | input | 1 | Word on dec_code_i is to be decoded |
| dec_code_i | input | 5 | Received five-line word |
| dec_valid_o | output | 1 | dec_data_o holds a newly decoded nibble |
| dec_data_o | output | 4 | Last correctly decoded nibble |
| dec_err_o | output | 1 | The last received word was not a code word |

## Verification
The hardest case to reach is a received word that has a legal weight but is not in the code book. The encoder never produces such a word, so a loop-back from encoder to decoder never covers it. The stimulus therefore drives the decoder input directly with all 32 five-bit values. Each non-code word follows a good one, which shows that the error flag rises while the nibble from the earlier word stays on the output. Random traffic with idle gaps on both paths then checks the hold behaviour on both sides.

// File: rtl/pbal_pkg.sv
package pbal_pkg;
  parameter int DATA_W = 4;
  parameter int CODE_W = 5;
  localparam int NUM_CODES = 1 << DATA_W;
  localparam int NUM_WORDS = 1 << CODE_W;
  localparam int LO_WT     = CODE_W / 2;
  localparam int HI_WT     = LO_WT + 1;

  function automatic int ones(input logic [CODE_W-1:0] w);
    int n = 0;
    for (int b = 0; b < CODE_W; b++) n += int'(w[b]);
    return n;
  endfunction

  // idx-th smallest word whose weight is LO_WT or HI_WT
  function automatic logic [CODE_W-1:0] code_of(input int idx);
    int seen = 0;
    logic [CODE_W-1:0] res = '0;
    for (int v = 0; v < NUM_WORDS; v++) begin
      if (ones(CODE_W'(v)) == LO_WT || ones(CODE_W'(v)) == HI_WT) begin
        if (seen == idx) res = CODE_W'(v);
        seen++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/pbal_rst_sync.sv
module pbal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pbal_enc_map.sv
module pbal_enc_map
  import pbal_pkg::*;
(
  input  logic [DATA_W-1:0] nibble,
  output logic [CODE_W-1:0] code,
  output logic              bal
);
  logic [CODE_W-1:0] tab [NUM_CODES];

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_tab
    assign tab[i] = code_of(i);
  end

  always_comb begin
    code = tab[nibble];
    bal  = ($countones(code) == LO_WT);
  end
endmodule

// File: rtl/pbal_dec_map.sv
module pbal_dec_map
  import pbal_pkg::*;
(
  input  logic [CODE_W-1:0] word,
  output logic [DATA_W-1:0] nibble,
  output logic              legal
);
  logic [NUM_CODES-1:0] hit;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
    localparam logic [CODE_W-1:0] K = code_of(i);
    assign hit[i] = (word == K);
  end

  always_comb begin
    nibble = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (hit[i]) nibble = nibble | DATA_W'(i);
    end
    legal = |hit;
  end
endmodule

// File: rtl/pbal_link.sv
module pbal_link
  import pbal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  output logic              enc_bal_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_err_o
);
  localparam logic [CODE_W-1:0] RST_CODE = code_of(0);
  localparam logic              RST_BAL  = ($countones(RST_CODE) == LO_WT);

  logic rst_sync_n;

  pbal_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // ---------------- transmit path ----------------
  logic [CODE_W-1:0] map_code;
  logic              map_bal;
  logic [CODE_W-1:0] code_q, code_d;
  logic              bal_q, bal_d, ev_q, ev_d;

  pbal_enc_map u_emap (.nibble(enc_data_i), .code(map_code), .bal(map_bal));

  always_comb begin
    code_d = code_q;
    bal_d  = bal_q;
    ev_d   = enc_valid_i;
    if (enc_valid_i) begin
      code_d = map_code;
      bal_d  = map_bal;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= RST_CODE;
      bal_q  <= RST_BAL;
      ev_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      bal_q  <= bal_d;
      ev_q   <= ev_d;
    end
  end

  assign enc_code_o  = code_q;
  assign enc_bal_o   = bal_q;
  assign enc_valid_o = ev_q;

  // ---------------- receive path ----------------
  logic [DATA_W-1:0] dmap_nib;
  logic              dmap_legal;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              dv_q, dv_d, de_q, de_d;

  pbal_dec_map u_dmap (.word(dec_code_i), .nibble(dmap_nib), .legal(dmap_legal));

  always_comb begin
    dat_d = dat_q;
    dv_d  = 1'b0;
    de_d  = 1'b0;
    if (dec_valid_i) begin
      if (dmap_legal) begin
        dat_d = dmap_nib;
        dv_d  = 1'b1;
      end else begin
        de_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dat_q <= '0;
      dv_q  <= 1'b0;
      de_q  <= 1'b0;
    end else begin
      dat_q <= dat_d;
      dv_q  <= dv_d;
      de_q  <= de_d;
    end
  end

  assign dec_data_o  = dat_q;
  assign dec_valid_o = dv_q;
  assign dec_err_o   = de_q;
endmodule

// File: rtl/pbal_link_chk.sv
module pbal_link_chk
  import pbal_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              enc_valid_i,
  input logic              enc_valid_o,
  input logic [CODE_W-1:0] enc_code_o,
  input logic              enc_bal_o,
  input logic              dec_valid_i,
  input logic [CODE_W-1:0] dec_code_i,
  input logic              dec_valid_o,
  input logic [DATA_W-1:0] dec_data_o,
  input logic              dec_err_o
);
  p_weight_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(enc_code_o) == LO_WT) || ($countones(enc_code_o) == HI_WT));

  p_three_high_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({enc_code_o, enc_bal_o}) == HI_WT);

  p_enc_latency_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    enc_valid_i |=> enc_valid_o);

  p_enc_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o) && $stable(enc_bal_o)));

  p_bad_weight_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid_i && ($countones(dec_code_i) < LO_WT || $countones(dec_code_i) > HI_WT))
      |=> dec_err_o);

  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dec_err_o && dec_valid_o));

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec_err_o |-> $stable(dec_data_o));

  p_dec_idle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dec_valid_i |=> (!dec_valid_o && !dec_err_o && $stable(dec_data_o)));
endmodule

bind pbal_link pbal_link_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .enc_valid_i(enc_valid_i), .enc_valid_o(enc_valid_o),
  .enc_code_o(enc_code_o), .enc_bal_o(enc_bal_o),
  .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
  .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o), .dec_err_o(dec_err_o)
);

// File: tb/pbal_link_tb_top.sv
`timescale 1ns/1ps
module pbal_link_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_valid_i = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic       dec_valid_i = 1'b0;
  logic [4:0] dec_code_i = '0;
  logic       enc_valid_o, enc_bal_o, dec_valid_o, dec_err_o;
  logic [4:0] enc_code_o;
  logic [3:0] dec_data_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int book [16];

  always #10 clk = ~clk;

  pbal_link dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o), .enc_bal_o(enc_bal_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o), .dec_err_o(dec_err_o)
  );

  function automatic int wt(input int v);
    int n = 0;
    for (int b = 0; b < 5; b++) if ((v >> b) & 1) n++;
    return n;
  endfunction

  function automatic int lookup(input int w);
    for (int k = 0; k < 16; k++) if (book[k] == w) return k;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_code = 3, m_bal = 1, m_ev = 0, m_dd = 0, m_dv = 0, m_de = 0;
  bit model_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code <= book[0]; m_bal <= 1; m_ev <= 0; m_dd <= 0; m_dv <= 0; m_de <= 0;
    end else begin
      m_ev <= int'(enc_valid_i);
      if (enc_valid_i) begin
        m_code <= book[enc_data_i];
        m_bal  <= (wt(book[enc_data_i]) == 2) ? 1 : 0;
      end
      m_dv <= 0; m_de <= 0;
      if (dec_valid_i) begin
        if (lookup(int'(dec_code_i)) >= 0) begin
          m_dd <= lookup(int'(dec_code_i)); m_dv <= 1;
        end else m_de <= 1;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (model_on) begin
      chk(int'(enc_code_o) == m_code, "R1 code", enc_code_o, m_code);
      chk(int'(enc_bal_o) == m_bal, "R3 bal", enc_bal_o, m_bal);
      chk(int'(enc_valid_o) == m_ev, "R4 enc_valid", enc_valid_o, m_ev);
      chk(int'(dec_data_o) == m_dd, "R6 dec_data", dec_data_o, m_dd);
      chk(int'(dec_valid_o) == m_dv, "R6 dec_valid", dec_valid_o, m_dv);
      chk(int'(dec_err_o) == m_de, "R9 dec_err", dec_err_o, m_de);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input bit ev, input int ed, input bit dv, input int dc);
    @(negedge clk);
    enc_valid_i = ev; enc_data_i = 4'(ed);
    dec_valid_i = dv; dec_code_i = 5'(dc);
  endtask

  task automatic settle();
    @(posedge clk); #6;
  endtask

  initial begin
    int n = 0;
    int held;
    for (int v = 0; v < 32; v++) if (wt(v) == 2 || wt(v) == 3) begin
      if (n < 16) book[n] = v;
      n++;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset values
    chk(enc_code_o == 5'd3, "R10 code", enc_code_o, 3);
    chk(enc_bal_o == 1'b1, "R10 bal", enc_bal_o, 1);
    chk({enc_valid_o, dec_valid_o, dec_err_o} == 3'b000, "R10 flags",
        {enc_valid_o, dec_valid_o, dec_err_o}, 0);
    chk(dec_data_o == 4'd0, "R10 data", dec_data_o, 0);
    model_on = 1'b1;

    // R1/R2/R6: every nibble, loop-back into decoder
    for (int v = 0; v < 16; v++) begin
      drive(1, v, 1, book[v]);
      settle();
      chk(int'(enc_code_o) == book[v], "R1 table", enc_code_o, book[v]);
      chk(wt(int'(enc_code_o)) == 2 || wt(int'(enc_code_o)) == 3, "R2 weight",
          wt(int'(enc_code_o)), 2);
      chk(wt(int'(enc_code_o)) + int'(enc_bal_o) == 3, "R3 sum",
          wt(int'(enc_code_o)) + int'(enc_bal_o), 3);
      chk(int'(dec_data_o) == v && dec_valid_o, "R6 roundtrip", dec_data_o, v);
    end

    // R5 / R11 idle hold
    drive(1, 9, 1, book[9]);
    drive(0, 2, 0, book[2]);
    repeat (3) begin
      settle();
      chk(int'(enc_code_o) == book[9] && !enc_valid_o, "R5 hold", enc_code_o, book[9]);
      chk(dec_data_o == 4'd9 && !dec_valid_o && !dec_err_o, "R11 idle", dec_data_o, 9);
    end

    // R7 / R8 / R9 every non-code word after a good one
    for (int w = 0; w < 32; w++) begin
      if (lookup(w) < 0) begin
        held = w % 16;
        drive(0, 0, 1, book[held]);
        drive(0, 0, 1, w);
        settle();
        if (wt(w) < 2 || wt(w) > 3)
          chk(dec_err_o == 1'b1, "R7 bad weight", dec_err_o, 1);
        else
          chk(dec_err_o == 1'b1, "R8 not in book", dec_err_o, 1);
        chk(int'(dec_data_o) == held && !dec_valid_o, "R9 data held", dec_data_o, held);
      end
    end
    drive(0, 0, 0, 0);

    // random traffic with gaps on both paths
    for (int i = 0; i < 300; i++)
      drive(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 31)));
    drive(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule